// File: doc/BRIEF.md
# Endianness-Selectable Byte-Addressed Word Memory

This block is a small synchronous memory built from 32-bit words, each word holding four 8-bit bytes. It is addressed in bytes, so the byte is the smallest unit a request can name. Words sit at byte addresses that are multiples of four. A single request port carries loads and stores of either one byte or one whole word. Load data comes back through a register one clock after the request.

A mode input selects how byte offsets inside a word map onto bit lanes. In big-endian numbering, offset 0 is the most significant byte. In little-endian numbering, offset 0 is the least significant byte. The mode only changes this mapping. It never rewrites or reorders what is already stored, and word accesses move all 32 bits unchanged in either mode.

A word request whose byte address is not a multiple of four is refused. The block raises a misalignment flag, writes nothing, and a refused load returns zero.

Top module: `endian_byte_mem`

## Requirements
- R1: While reset is active and on the first cycle after it, `rdata` is 0, `rvalid` is 0 and `misaligned` is 0.
- R2: An aligned word store (`byte_sz`=0, `addr[1:0]`=0) followed later by a word load of the same address returns the stored 32 bits. `rvalid` is 1 in exactly the cycle after each accepted load and 0 otherwise.
- R3: With `mode_be`=1, byte offset `addr[1:0]`=o selects bits [31-8o : 24-8o] of the word, so offset 0 is bits 31:24.
- R4: With `mode_be`=0, byte offset o selects bits [8o+7 : 8o], so offset 0 is bits 7:0.
- R5: A byte load returns the selected byte in `rdata[7:0]`, with `rdata[31:8]` equal to 0.
- R6: A byte store writes `wdata[7:0]` into the selected lane only. The other three lanes of that word keep their values.
- R7: A word request with `addr[1:0]` not 0 sets `misaligned` to 1 in the next cycle and writes nothing. If it is a load, `rdata` is 0 and `rvalid` is 1 in that cycle. Any other request or idle cycle leaves `misaligned` at 0 in the next cycle.
- R8: A load leaves the stored contents unchanged. `rdata` keeps its value through every cycle that follows a cycle with no load.
- R9: Changing `mode_be` does not alter the stored bits. A word stored in one mode reads back identically in the other.
- R10: The word index is `addr[ADDR_W-1:2]`. The last word, at byte address 2^ADDR_W − 4, can be stored and loaded like any other word.
- R11: A store takes effect at the clock edge that accepts it. A load issued in the next cycle sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_be | input | 1 | 1 = big-endian byte numbering, 0 = little-endian |
| req | input | 1 | Request accepted on this edge |
| we | input | 1 | 1 = store, 0 = load |
| byte_sz | input | 1 | 1 = byte access, 0 = word access |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Store data; a byte store uses bits 7:0 |
| rdata | output | 32 | Registered load data |
| rvalid | output | 1 | Load data valid this cycle |
| misaligned | output | 1 | Previous request was a refused unaligned word access |

## Verification
The assertions assume a single request per cycle, with `req`, `we`, `byte_sz` and `addr` settled before each rising edge. They also assume `req` is held low during reset, so that no property looks back at a request made while reset was active. The bench drives all inputs on the falling edge and keeps `req` low throughout reset. Before any load, it stores every word in the array, so no load can return contents that were never written. The random phase mixes modes, sizes, offsets and directions freely, because every combination is a legal input.

// File: rtl/ebm_pkg.sv
// Package: shared widths and types for the endianness-selectable memory.
// Assumes a fixed four-byte word; the address width is set by the top.
package ebm_pkg;
    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int LANES   = WORD_W / BYTE_W;
    localparam int LANE_W  = $clog2(LANES);

    typedef logic [LANE_W-1:0] lane_t;

    typedef enum logic {
        ACC_WORD = 1'b0,
        ACC_BYTE = 1'b1
    } acc_size_e;
endpackage

// File: rtl/ebm_addr_decode.sv
// Module: ebm_addr_decode
// Splits a byte address into a word index and a physical bit lane.
// The lane depends on the numbering mode. Flags word accesses that are
// not on a four-byte boundary. Purely combinational.
module ebm_addr_decode
    import ebm_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int IDX_W = ADDR_W - LANE_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  acc_size_e         size,
    input  logic              mode_be,
    output logic [IDX_W-1:0]  word_idx,
    output lane_t             lane,
    output logic              unaligned
);
    lane_t offset;

    // Decode index, offset-to-lane mapping and alignment.
    always_comb begin
        offset    = addr[LANE_W-1:0];
        word_idx  = addr[ADDR_W-1:LANE_W];
        // Big-endian: offset 0 is the top lane, i.e. lane = 3 - offset.
        lane      = mode_be ? lane_t'(LANES - 1 - int'(offset)) : offset;
        unaligned = (size == ACC_WORD) && (offset != '0);
    end
endmodule

// File: rtl/ebm_word_array.sv
// Module: ebm_word_array
// Word storage split into one byte-wide bank per lane. Each lane has its own
// write enable. The read port is registered and is cleared by reset; the
// storage itself is not reset. Assumes one access (read or write) per cycle.
module ebm_word_array
    import ebm_pkg::*;
#(
    parameter int IDX_W = 6,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LANES-1:0]  byte_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] rd_word
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] bank [DEPTH];
        logic [BYTE_W-1:0] q;

        // Write this lane's byte when the lane is enabled.
        always_ff @(posedge clk) begin
            if (wr_en && byte_en[g]) begin
                bank[idx] <= wr_data[g*BYTE_W +: BYTE_W];
            end
        end

        // Capture this lane's byte on a read; hold it otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (rd_en) begin
                q <= bank[idx];
            end
        end

        assign rd_word[g*BYTE_W +: BYTE_W] = q;
    end
endmodule

// File: rtl/ebm_lane_steer.sv
// Module: ebm_lane_steer
// Write side: builds the lane enables and places the store data on the
// lanes. Read side: selects and zero-extends a byte, passes a whole word,
// or forces zero for a refused load. Purely combinational.
module ebm_lane_steer
    import ebm_pkg::*;
(
    input  acc_size_e         wr_size,
    input  lane_t             wr_lane,
    input  logic [WORD_W-1:0] wdata,
    output logic [LANES-1:0]  byte_en,
    output logic [WORD_W-1:0] wr_data,
    input  acc_size_e         rd_size,
    input  lane_t             rd_lane,
    input  logic              rd_kill,
    input  logic [WORD_W-1:0] raw_word,
    output logic [WORD_W-1:0] rdata
);
    // Lane enables and data placement for stores.
    always_comb begin
        if (wr_size == ACC_BYTE) begin
            byte_en = LANES'(1) << wr_lane;
            wr_data = {LANES{wdata[BYTE_W-1:0]}};
        end else begin
            byte_en = '1;
            wr_data = wdata;
        end
    end

    // Shape the registered word into load data.
    always_comb begin
        if (rd_kill) begin
            rdata = '0;
        end else if (rd_size == ACC_BYTE) begin
            rdata = WORD_W'(raw_word[rd_lane*BYTE_W +: BYTE_W]);
        end else begin
            rdata = raw_word;
        end
    end
endmodule

// File: rtl/endian_byte_mem.sv
// Module: endian_byte_mem (top)
// Byte-addressed memory of 32-bit words. Loads and stores are byte or word
// sized, and byte numbering is big- or little-endian by mode_be. Stores
// land on the accepting edge; loads return one cycle later. Unaligned word
// requests are refused and flagged. Assumes req is low during reset.
module endian_byte_mem
    import ebm_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int IDX_W = ADDR_W - LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_be,
    input  logic              req,
    input  logic              we,
    input  logic              byte_sz,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid,
    output logic              misaligned
);
    acc_size_e         size;
    logic [IDX_W-1:0]  word_idx;
    lane_t             lane;
    logic              unaligned;
    logic [LANES-1:0]  byte_en;
    logic [WORD_W-1:0] wr_data;
    logic [WORD_W-1:0] raw_word;
    logic              wr_fire;
    logic              rd_fire;
    logic              ld_req;

    acc_size_e         rd_size_q;
    lane_t             rd_lane_q;
    logic              rd_kill_q;
    logic              rvalid_q;
    logic              mis_q;

    assign size = byte_sz ? ACC_BYTE : ACC_WORD;

    ebm_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr      (addr),
        .size      (size),
        .mode_be   (mode_be),
        .word_idx  (word_idx),
        .lane      (lane),
        .unaligned (unaligned)
    );

    // Qualify the request into a write, a read or a plain load request.
    always_comb begin
        ld_req  = req && !we;
        wr_fire = req && we && !unaligned;
        rd_fire = ld_req && !unaligned;
    end

    ebm_word_array #(.IDX_W(IDX_W)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_fire),
        .byte_en (byte_en),
        .wr_data (wr_data),
        .rd_en   (rd_fire),
        .idx     (word_idx),
        .rd_word (raw_word)
    );

    // Remember how to shape the load data that returns next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_size_q <= ACC_WORD;
            rd_lane_q <= '0;
            rd_kill_q <= 1'b0;
        end else if (ld_req) begin
            rd_size_q <= size;
            rd_lane_q <= lane;
            rd_kill_q <= unaligned;
        end
    end

    // Registered valid and misalignment pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            mis_q    <= 1'b0;
        end else begin
            rvalid_q <= ld_req;
            mis_q    <= req && unaligned;
        end
    end

    ebm_lane_steer u_steer (
        .wr_size  (size),
        .wr_lane  (lane),
        .wdata    (wdata),
        .byte_en  (byte_en),
        .wr_data  (wr_data),
        .rd_size  (rd_size_q),
        .rd_lane  (rd_lane_q),
        .rd_kill  (rd_kill_q),
        .raw_word (raw_word),
        .rdata    (rdata)
    );

    assign rvalid     = rvalid_q;
    assign misaligned = mis_q;
endmodule

// File: rtl/ebm_checker.sv
// Module: ebm_checker
// Port-level properties of endian_byte_mem, attached by bind below.
// Assumes req is held low while reset is active.
module ebm_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              we,
    input logic              byte_sz,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       rdata,
    input logic              rvalid,
    input logic              misaligned
);
    logic in_rst_d;

    // Note whether the previous edge was a reset edge.
    always_ff @(posedge clk) in_rst_d <= !rst_n;

    // R1: outputs are quiet on the cycle after a reset edge.
    always_ff @(posedge clk) begin
        if (rst_n && in_rst_d) begin
            p_reset_quiet_r1: assert (rdata == '0 && !rvalid && !misaligned)
                else $error("reset state not quiet");
        end
    end

    // R2: rvalid follows every load request by exactly one cycle.
    p_rvalid_after_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we) |=> rvalid);
    p_rvalid_only_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && !we) |=> !rvalid);

    // R5: byte loads are zero-extended.
    p_byte_zext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && byte_sz) |=> (rdata[31:8] == '0));

    // R7: an unaligned word request raises the flag; a refused load gives 0.
    p_flag_unaligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !byte_sz && addr[1:0] != 2'b00) |=> misaligned);
    p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && !byte_sz && addr[1:0] != 2'b00) |=> !misaligned);
    p_refused_load_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && !byte_sz && addr[1:0] != 2'b00) |=> (rdata == '0));

    // R8: load data holds when no load was requested.
    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && !we) |=> $stable(rdata));
endmodule

bind endian_byte_mem ebm_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_endian_byte_mem.sv
// Bench: behavioural reference model compared with the outputs every clock.
module sim_endian_byte_mem;
    localparam int PERIOD = 10;
    localparam int AW     = 8;
    localparam int NWORDS = 1 << (AW - 2);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          mode_be, req, we, byte_sz;
    logic [AW-1:0] addr;
    logic [31:0]   wdata;
    logic [31:0]   rdata;
    logic          rvalid, misaligned;

    int unsigned   vectors = 0;
    int unsigned   fails   = 0;

    logic [31:0]   ref_mem [NWORDS];
    logic [31:0]   exp_rdata = '0;
    logic          exp_rv    = 1'b0;
    logic          exp_mis   = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    endian_byte_mem #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_be(mode_be), .req(req), .we(we),
        .byte_sz(byte_sz), .addr(addr), .wdata(wdata), .rdata(rdata),
        .rvalid(rvalid), .misaligned(misaligned)
    );

    function automatic int lane_of(input logic be, input logic [1:0] off);
        return be ? 3 - int'(off) : int'(off);
    endfunction

    task automatic compare(input string tag);
        vectors++;
        if (rdata !== exp_rdata || rvalid !== exp_rv || misaligned !== exp_mis) begin
            fails++;
            $display("FAIL %s: rdata=%h rvalid=%b mis=%b expected rdata=%h rvalid=%b mis=%b",
                     tag, rdata, rvalid, misaligned, exp_rdata, exp_rv, exp_mis);
        end
    endtask

    // One clock of stimulus, model update and comparison.
    task automatic step(input logic r, input logic w, input logic b,
                        input logic [AW-1:0] a, input logic [31:0] d,
                        input logic m, input string tag);
        @(negedge clk);
        req = r; we = w; byte_sz = b; addr = a; wdata = d; mode_be = m;
        @(posedge clk);
        exp_rv  = 1'b0;
        exp_mis = 1'b0;
        if (r) begin
            if (!b && a[1:0] != 2'b00) begin
                exp_mis = 1'b1;
                if (!w) begin
                    exp_rv = 1'b1;
                    exp_rdata = '0;
                end
            end else if (w) begin
                if (b) ref_mem[a >> 2][lane_of(m, a[1:0])*8 +: 8] = d[7:0];
                else   ref_mem[a >> 2] = d;
            end else begin
                exp_rv = 1'b1;
                exp_rdata = b ? {24'h0, ref_mem[a >> 2][lane_of(m, a[1:0])*8 +: 8]}
                              : ref_mem[a >> 2];
            end
        end
        #(PERIOD/4);
        compare(tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b0, 1'b0, '0, '0, 1'b0, tag);
    endtask

    initial begin
        #(PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req = 1'b0; we = 1'b0; byte_sz = 1'b0;
        addr = '0; wdata = '0; mode_be = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #(PERIOD/4);
        compare("R1 reset state");

        // R2/R10: fill every word, including the last one.
        for (int i = 0; i < NWORDS; i++)
            step(1, 1, 0, AW'(i * 4), 32'hA5C3_0000 ^ (i * 32'h0103_0507), i[0], "R2 fill");
        step(1, 0, 0, AW'(0), '0, 0, "R2 word load");
        step(1, 0, 0, AW'((1 << AW) - 4), '0, 1, "R10 last word load");
        step(1, 1, 0, AW'((1 << AW) - 4), 32'hDEAD_BEEF, 0, "R10 last word store");
        step(1, 0, 0, AW'((1 << AW) - 4), '0, 0, "R10 last word readback");

        // R3/R4/R5: byte loads of a known word in both numberings.
        step(1, 1, 0, AW'(12), 32'h1122_3344, 0, "R3 setup");
        for (int o = 0; o < 4; o++) step(1, 0, 1, AW'(12 + o), '0, 1, "R3 R5 big-endian byte load");
        for (int o = 0; o < 4; o++) step(1, 0, 1, AW'(12 + o), '0, 0, "R4 R5 little-endian byte load");

        // R6: byte stores touch one lane only.
        step(1, 1, 1, AW'(21), 32'hFFFF_FF7E, 1, "R6 big-endian byte store");
        step(1, 0, 0, AW'(20), '0, 1, "R6 word after byte store");
        step(1, 1, 1, AW'(25), 32'h0000_00E1, 0, "R6 little-endian byte store");
        step(1, 0, 0, AW'(24), '0, 0, "R6 word after byte store");

        // R7: refused unaligned word store and load.
        step(1, 1, 0, AW'(9), 32'h0BAD_0BAD, 0, "R7 unaligned store");
        step(1, 0, 0, AW'(8), '0, 0, "R7 word unchanged");
        step(1, 0, 0, AW'(10), '0, 1, "R7 unaligned load");
        idle("R7 flag clears");

        // R8: repeated loads keep contents; rdata holds while idle.
        step(1, 0, 0, AW'(16), '0, 0, "R8 load");
        step(1, 0, 0, AW'(16), '0, 0, "R8 load again");
        idle("R8 hold");
        idle("R8 hold");

        // R9: a mode switch leaves stored bits alone.
        step(1, 1, 0, AW'(28), 32'hCAFE_F00D, 1, "R9 store big-endian");
        step(1, 0, 0, AW'(28), '0, 0, "R9 load little-endian");
        step(1, 0, 1, AW'(28), '0, 0, "R9 byte 0 little-endian");
        step(1, 0, 1, AW'(28), '0, 1, "R9 byte 0 big-endian");

        // R11: store then load on the next cycle.
        step(1, 1, 0, AW'(32), 32'h0F1E_2D3C, 0, "R11 store");
        step(1, 0, 0, AW'(32), '0, 0, "R11 next-cycle load");
        step(1, 1, 1, AW'(34), 32'h0000_0099, 1, "R11 byte store");
        step(1, 0, 0, AW'(32), '0, 1, "R11 next-cycle load");

        // Mixed traffic across all modes, sizes and offsets.
        for (int i = 0; i < 600; i++)
            step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                 $urandom_range(0, 1) == 1, AW'($urandom), $urandom,
                 $urandom_range(0, 1) == 1, "R2 R3 R4 R6 R7 mixed");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule